// File: doc/BRIEF.md
# Printer Port Register Block

This block gives a host bus a byte-wide view of a legacy printer port through three registers: a data register, a status register and a control register. The host selects a register with the low three bits of its address, so the register window repeats every eight addresses. Offsets 3 to 7 are empty: they read as all ones and swallow writes.

The printer on the far side is not sampled from pins. It is modelled inside the block as a small handshake. Control writes and status reads move the busy flag, the acknowledge flag and an interrupt-pending flag through a fixed order of steps. When software raises the strobe bit, the byte held in the output data latch leaves the block as a one-cycle pulse on a valid/byte stream. A separate input latch, loaded from an external byte port, is what a data read returns while the direction bit selects input. The interrupt pin is a registered level that follows the pending flag.

Top module: `printer_port_regs`

## Requirements
- R1: The register offset is the bus address modulo 8. Offset 0 is data, 1 is status, 2 is control. A read at offsets 3 to 7 returns 0xFF, and a write there changes no register.
- R2: After reset, a data read returns 0xFF, status reads 0xD9, control reads 0xCC, and both the irq and out_valid outputs are 0.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1. A control read returns the stored value.
- R4: A control write with bit 2 (init) equal to 0 sets status to exactly 0xD8: not-busy (bit 7), acknowledge (bit 6), online (bit 4) and not-error (bit 3) set, all other bits clear.
- R5: A control write with init=1, select-in (bit 3)=1 and strobe (bit 0)=1 clears status bit 7. If the stored strobe bit was 0 before the write, out_valid is 1 for the cycle after the write and out_byte carries the output data latch.
- R6: A control write with init=1, select-in=1 and strobe=0 sets the pending flag when the stored control value before the write had bit 4 (interrupt enable) set. irq shows the pending flag in the cycle after the write.
- R7: A status read returns the status as it was before the read and clears the pending flag, so irq is 0 in the cycle after the read.
- R8: After a status read, if status bit 7 was 0 and the stored strobe bit is 0: when bit 6 was set it is cleared; otherwise bits 7 and 6 are both set. Otherwise status does not change.
- R9: A data read returns the input latch when control bit 5 is 1, and the output latch when it is 0. The input latch takes ext_data in any cycle where ext_load is 1.
- R10: Every read gives rsp_valid=1 with the data on rsp_data in the next cycle; rsp_valid is 0 in cycles after a write or an idle cycle.
- R11: A control write with init=1 and select-in=0 stores control but leaves status, the pending flag and the output stream unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address; low three bits select the register |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | 8 | Read data |
| ext_data | input | 8 | Byte for the input data latch |
| ext_load | input | 1 | Load ext_data into the input latch |
| out_valid | output | 1 | One-cycle pulse when a byte is sent to the printer |
| out_byte | output | 8 | Byte sent to the printer |
| irq | output | 1 | Level interrupt, follows the pending flag |

## Verification
The bench sweeps every control byte from a running state, each preceded by a fresh data byte and followed by two status reads, so every init/select/strobe/enable combination meets both stored strobe values and both acknowledge phases; a design that tested the new strobe bit instead of the stored one would emit twice or never, and one that tested the new enable bit would raise irq a write too early. The acknowledge walk is checked by repeated status reads, where a wrong branch would freeze the status at 0x59 or skip straight to 0xD9. Address aliasing above offset 7, ignored writes at empty offsets and the direction bit choosing between the two data latches each get directed cases, where a missing mask would hit the wrong register or return the wrong latch.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

    localparam int DATA_W = 8;
    localparam int OFF_W  = 3;

    localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
    localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

    // status bit positions
    localparam int ST_NBUSY = 7;
    localparam int ST_ACK   = 6;

    // control bit positions
    localparam int CT_DIR    = 5;
    localparam int CT_IEN    = 4;
    localparam int CT_SELIN  = 3;
    localparam int CT_INIT   = 2;
    localparam int CT_STROBE = 0;

    localparam logic [DATA_W-1:0] CT_FORCED   = 8'hC0;
    localparam logic [DATA_W-1:0] ST_RESET    = 8'hD9;
    localparam logic [DATA_W-1:0] ST_INITDONE = 8'hD8;
    localparam logic [DATA_W-1:0] CT_RESET    = 8'hCC;
    localparam logic [DATA_W-1:0] BYTE_ONES   = 8'hFF;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] din;
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] ctrl;
        logic              pend;
        logic              irq;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic              out_valid;
        logic [DATA_W-1:0] out_byte;
    } ppr_state_t;

endpackage

// File: rtl/ppr_decode.sv
module ppr_decode
    import ppr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic [OFF_W-1:0]  off,
    output logic              rd_any,
    output logic              wr_data,
    output logic              wr_ctrl,
    output logic              rd_stat
);
    always_comb begin
        off     = addr[OFF_W-1:0];
        rd_any  = sel && !wr;
        wr_data = sel && wr && (off == OFF_DATA);
        wr_ctrl = sel && wr && (off == OFF_CTRL);
        rd_stat = sel && !wr && (off == OFF_STAT);
    end
endmodule

// File: rtl/ppr_handshake.sv
module ppr_handshake
    import ppr_pkg::*;
(
    input  logic [DATA_W-1:0] status_q,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic              pend_q,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_ctrl,
    input  logic              rd_stat,
    output logic [DATA_W-1:0] status_d,
    output logic              pend_d,
    output logic              emit
);
    logic [DATA_W-1:0] ctl_new;

    always_comb begin
        ctl_new  = wdata | CT_FORCED;
        status_d = status_q;
        pend_d   = pend_q;
        emit     = 1'b0;

        if (wr_ctrl) begin
            if (!ctl_new[CT_INIT]) begin
                status_d = ST_INITDONE;
            end else if (ctl_new[CT_SELIN]) begin
                if (ctl_new[CT_STROBE]) begin
                    status_d[ST_NBUSY] = 1'b0;
                    emit = !ctrl_q[CT_STROBE];
                end else if (ctrl_q[CT_IEN]) begin
                    pend_d = 1'b1;
                end
            end
        end

        if (rd_stat) begin
            pend_d = 1'b0;
            if (!status_q[ST_NBUSY] && !ctrl_q[CT_STROBE]) begin
                if (status_q[ST_ACK]) begin
                    status_d[ST_ACK] = 1'b0;
                end else begin
                    status_d[ST_ACK]   = 1'b1;
                    status_d[ST_NBUSY] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/printer_port_regs.sv
module printer_port_regs
    import ppr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    input  logic [7:0]        ext_data,
    input  logic              ext_load,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              irq
);
    ppr_state_t st_d, st_q;

    logic [OFF_W-1:0]  off;
    logic              rd_any, wr_data, wr_ctrl, rd_stat;
    logic [DATA_W-1:0] hs_status;
    logic              hs_pend, hs_emit;
    logic [DATA_W-1:0] ctrl_q;

    ppr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .off     (off),
        .rd_any  (rd_any),
        .wr_data (wr_data),
        .wr_ctrl (wr_ctrl),
        .rd_stat (rd_stat)
    );

    ppr_handshake u_hs (
        .status_q (st_q.status),
        .ctrl_q   (st_q.ctrl),
        .pend_q   (st_q.pend),
        .wdata    (bus_wdata),
        .wr_ctrl  (wr_ctrl),
        .rd_stat  (rd_stat),
        .status_d (hs_status),
        .pend_d   (hs_pend),
        .emit     (hs_emit)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = rd_any;
        st_d.out_valid = 1'b0;
        st_d.status    = hs_status;
        st_d.pend      = hs_pend;

        if (wr_data) st_d.dout = bus_wdata;
        if (wr_ctrl) st_d.ctrl = bus_wdata | CT_FORCED;
        if (ext_load) st_d.din = ext_data;

        if (hs_emit) begin
            st_d.out_valid = 1'b1;
            st_d.out_byte  = st_q.dout;
        end

        if (wr_data || wr_ctrl || rd_stat) st_d.irq = hs_pend;

        if (rd_any) begin
            case (off)
                OFF_DATA: st_d.rsp_data = st_q.ctrl[CT_DIR] ? st_q.din : st_q.dout;
                OFF_STAT: st_d.rsp_data = st_q.status;
                OFF_CTRL: st_d.rsp_data = st_q.ctrl;
                default:  st_d.rsp_data = BYTE_ONES;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dout      <= BYTE_ONES;
            st_q.din       <= BYTE_ONES;
            st_q.status    <= ST_RESET;
            st_q.ctrl      <= CT_RESET;
            st_q.pend      <= 1'b0;
            st_q.irq       <= 1'b0;
            st_q.rsp_valid <= 1'b0;
            st_q.rsp_data  <= '0;
            st_q.out_valid <= 1'b0;
            st_q.out_byte  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q    = st_q.ctrl;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
    assign out_valid = st_q.out_valid;
    assign out_byte  = st_q.out_byte;
    assign irq       = st_q.irq;
endmodule

// File: rtl/ppr_checker.sv
module ppr_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              rsp_valid,
    input logic [7:0]        rsp_data,
    input logic              out_valid,
    input logic              irq,
    input logic [7:0]        ctrl_q
);
    logic [2:0] off;
    assign off = bus_addr[2:0];

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> rsp_valid); // R10

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> !rsp_valid); // R10

    AST_EMPTY_OFFSET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && off > 3'd2) |=> (rsp_data == 8'hFF)); // R1

    AST_EMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bus_sel && bus_wr && off == 3'd2 &&
                            bus_wdata[0] && bus_wdata[2] && bus_wdata[3])); // R5

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(bus_sel && bus_wr && off == 3'd2 && !bus_wdata[0])); // R6

    AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && off == 3'd1) |=> !irq); // R7

    AST_CTRL_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[7:6] == 2'b11); // R3
endmodule

bind printer_port_regs ppr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .out_valid (out_valid),
    .irq       (irq),
    .ctrl_q    (ctrl_q)
);

// File: tb/printer_port_regs_test.sv
module printer_port_regs_test;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          rsp_valid;
    logic [7:0]    rsp_data;
    logic [7:0]    ext_data = '0;
    logic          ext_load = 1'b0;
    logic          out_valid;
    logic [7:0]    out_byte;
    logic          irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model of the register state
    logic [7:0] m_dw, m_dr, m_st, m_ct;
    logic       m_pend;

    always #10 clk = ~clk;

    printer_port_regs #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .ext_data(ext_data), .ext_load(ext_load),
        .out_valid(out_valid), .out_byte(out_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC; m_pend = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v, input string req);
        logic [7:0] c;
        logic       emit;
        logic [7:0] eb;
        emit = 1'b0;
        eb   = m_dw;
        c    = v | 8'hC0;
        case (a[2:0])
            3'd0: m_dw = v;
            3'd2: begin
                if (!c[2]) m_st = 8'hD8;                        // R4
                else if (c[3]) begin
                    if (c[0]) begin m_st[7] = 1'b0; emit = !m_ct[0]; end // R5
                    else if (m_ct[4]) m_pend = 1'b1;            // R6
                end
                m_ct = c;                                       // R3
            end
            default: ;                                          // R1
        endcase
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk({req, " out_valid"}, {7'd0, out_valid}, {7'd0, emit});
        if (emit) chk({req, " out_byte"}, out_byte, eb);
        chk({req, " irq"}, {7'd0, irq}, {7'd0, m_pend});
        chk({req, " R10 no rsp"}, {7'd0, rsp_valid}, 8'd0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string req);
        logic [7:0] exp;
        case (a[2:0])
            3'd0: exp = m_ct[5] ? m_dr : m_dw;                  // R9
            3'd1: begin
                exp = m_st;
                m_pend = 1'b0;                                  // R7
                if (!m_st[7] && !m_ct[0]) begin                 // R8
                    if (m_st[6]) m_st[6] = 1'b0;
                    else m_st[7:6] = 2'b11;
                end
            end
            3'd2: exp = m_ct;
            default: exp = 8'hFF;
        endcase
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        chk({req, " R10 rsp_valid"}, {7'd0, rsp_valid}, 8'd1);
        chk({req, " data"}, rsp_data, exp);
        chk({req, " irq"}, {7'd0, irq}, {7'd0, m_pend});
        chk({req, " out_valid"}, {7'd0, out_valid}, 8'd0);
    endtask

    task automatic load_in(input logic [7:0] v);
        m_dr = v;
        ext_load = 1'b1; ext_data = v;
        @(posedge clk);
        @(negedge clk);
        ext_load = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 irq", {7'd0, irq}, 8'd0);
        chk("R2 out_valid", {7'd0, out_valid}, 8'd0);
        rd(4'd0, "R2 data");
        chk("R2 data lit", rsp_data, 8'hFF);
        rd(4'd2, "R2 ctrl");
        chk("R2 ctrl lit", rsp_data, 8'hCC);
        rd(4'd1, "R2 status");
        chk("R2 status lit", rsp_data, 8'hD9);

        // R5 / R8 print cycle with literal values
        wr(4'd0, 8'h41, "R5 data");
        wr(4'd2, 8'h0D, "R5 strobe");
        chk("R5 byte lit", out_byte, 8'h41);
        wr(4'd2, 8'h0C, "R5 strobe low");
        rd(4'd1, "R8 read1");
        chk("R8 busy", rsp_data, 8'h59);
        rd(4'd1, "R8 read2");
        chk("R8 ack cleared", rsp_data, 8'h19);
        rd(4'd1, "R8 read3");
        chk("R8 ack busy set", rsp_data, 8'hD9);

        // R6 / R7 interrupt
        wr(4'd2, 8'h1C, "R6 enable");
        chk("R6 not yet", {7'd0, irq}, 8'd0);
        wr(4'd2, 8'h1C, "R6 pend");
        chk("R6 irq lit", {7'd0, irq}, 8'd1);
        rd(4'd1, "R7 clear");
        chk("R7 irq lit", {7'd0, irq}, 8'd0);

        // R11 select low: control stored only
        wr(4'd2, 8'h15, "R11 sel low");
        rd(4'd2, "R11 ctrl");
        chk("R11 ctrl lit", rsp_data, 8'hD5);

        // R4 init low
        wr(4'd2, 8'h00, "R4 init");
        rd(4'd1, "R4 status");
        chk("R4 status lit", rsp_data, 8'hD8);

        // R1 aliasing and empty offsets
        wr(4'd10, 8'h08, "R1 alias ctrl");
        rd(4'd2, "R1 alias readback");
        chk("R1 alias lit", rsp_data, 8'hC8);
        for (int k = 3; k < 16; k++) begin
            if (k[2:0] > 3'd2) begin
                wr(k[AW-1:0], 8'h00, "R1 empty wr");
                rd(k[AW-1:0], "R1 empty rd");
            end
        end
        rd(4'd0, "R1 data kept");
        rd(4'd1, "R1 status kept");
        rd(4'd2, "R1 ctrl kept");

        // R9 direction
        load_in(8'h96);
        wr(4'd2, 8'h2C, "R9 dir in");
        rd(4'd0, "R9 in latch");
        chk("R9 in lit", rsp_data, 8'h96);
        wr(4'd2, 8'h0C, "R9 dir out");
        rd(4'd0, "R9 out latch");

        // sweep of all control bytes
        for (int v = 0; v < 256; v++) begin
            if (v % 16 == 0) load_in(8'(v ^ 8'hA5));
            wr(4'd0, 8'(v ^ 8'h3C), "R5 sweep data");
            wr(4'd2, 8'(v), "R3 sweep ctrl");
            rd(4'd1, "R8 sweep st1");
            rd(4'd1, "R8 sweep st2");
            rd(4'(8 + 2), "R3 sweep ctrl rd");
            rd(4'd0, "R9 sweep data");
            wr(4'd2, 8'(v ^ 8'h11), "R6 sweep ctrl2");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule